// File: doc/BRIEF.md
# Two-Port Mailbox with In-Memory Ready Flag

This block couples two neighbouring pipeline stages through a small two-port word store. One stage, the producer, owns port A; the next stage, the consumer, owns port B. Each port is a plain synchronous read/write interface that completes one access per cycle. One word of the store is set aside as a ready flag. A few words just below the flag form the mailbox data window. The producer fills the window and then writes 1 to the flag. The consumer polls the flag, takes the data and writes 0 back. All other words are general shared storage. Stages that are not adjacent can use them to pass values through.

The hardware guards the handshake in three ways. While the flag reads full, producer writes into the data window are dropped. If both ports write the flag in the same cycle, this is reported as a collision and port A's value is kept. A notify line tells the consumer when data is ready. A mode input selects its form. In poll mode it follows the flag level. In interrupt mode it gives a single-cycle pulse when the flag goes from empty to full.

Top module: `mbx_mailbox`

## Requirements
- R1: While reset is low and on the first cycle after it, the flag is empty (0), `notify` is 0 and `collide` is 0.
- R2: A read issued on a port returns its word on that port's `rdata` in the cycle after the request, and `rdata` holds that word until the port's next read. A word written by one port can be read by the other port starting in the next cycle.
- R3: The flag lives at address `FLAG_ADDR` (default 1023). Writing there stores only bit 0 of the write data, where 1 means full and 0 means empty. Reading there returns a 16-bit word whose bit 0 is the flag and whose other bits are 0.
- R4: While the flag is full, a port A write to the data window (addresses `DATA_BASE` to `DATA_BASE+DATA_WORDS-1`, default 1016 to 1019) is ignored, and the word keeps its old value.
- R5: Port A writes outside the data window and the flag word take effect regardless of the flag state.
- R6: When both ports write the flag in the same cycle, the flag takes port A's bit 0, and `collide` is 1 for exactly the next cycle.
- R7: With `cfg_irq_mode` = 0 (poll), `notify` equals the current flag level.
- R8: With `cfg_irq_mode` = 1 (interrupt), `notify` is 1 for exactly one cycle after the flag changes from 0 to 1. Writing 1 to a flag that is already full gives no pulse.
- R9: When both ports write the same non-flag address in the same cycle, port A's data is stored.
- R10: A read on one port of an address that the other port writes in the same cycle returns the old word.
- R11: A producer and a consumer that follow the flag protocol with random delays pass a stream of words with none lost and none duplicated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_irq_mode | input | 1 | Notify form: 0 level (poll), 1 single-cycle pulse (interrupt) |
| a_en | input | 1 | Port A access request |
| a_we | input | 1 | Port A write (1) or read (0) |
| a_addr | input | 10 | Port A word address |
| a_wdata | input | 16 | Port A write data |
| a_rdata | output | 16 | Port A read data, valid the cycle after a read |
| b_en | input | 1 | Port B access request |
| b_we | input | 1 | Port B write (1) or read (0) |
| b_addr | input | 10 | Port B word address |
| b_wdata | input | 16 | Port B write data |
| b_rdata | output | 16 | Port B read data, valid the cycle after a read |
| notify | output | 1 | Ready indication to the consumer |
| collide | output | 1 | One-cycle report of a simultaneous flag write |

## Verification
The bench targets the cases where a simple design goes wrong. A producer that overwrites the data window while the flag is full would corrupt the word the consumer has not yet read. A pulse generator that fires on every write of 1, rather than on the 0-to-1 edge, would interrupt the consumer twice for one datum. A collision handled the wrong way would let the consumer's clear win and drop a datum. A store that returns newly written data to a read on the other port in the same cycle would break the polling loop. The random-delay stream shows lost words as gaps in the received sequence and duplicated words as repeats.

// File: rtl/mbx_pkg.sv
// Package: shared types and default sizes for the two-port mailbox.
// Assumes: the notify form is picked by a single configuration bit.
package mbx_pkg;

    // Selectable form of the consumer notify line
    typedef enum logic {
        NOTIFY_LEVEL = 1'b0,
        NOTIFY_PULSE = 1'b1
    } notify_form_e;

    localparam int MBX_DATA_W  = 16;
    localparam int MBX_DEPTH   = 1024;

endpackage

// File: rtl/mbx_store.sv
// Module: two-port word store, one synchronous access per port per cycle.
// Assumes: write enables arrive already filtered by the flag controller;
// reads return the word held before any write in the same cycle; on a
// same-address double write port A is stored last and therefore wins.
module mbx_store #(
    parameter int DW    = 16,
    parameter int DEPTH = 1024,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          a_we,
    input  logic          a_re,
    input  logic [AW-1:0] a_addr,
    input  logic [DW-1:0] a_wdata,
    output logic [DW-1:0] a_rdata,
    input  logic          b_we,
    input  logic          b_re,
    input  logic [AW-1:0] b_addr,
    input  logic [DW-1:0] b_wdata,
    output logic [DW-1:0] b_rdata
);

    logic [DW-1:0] words [DEPTH];

    // Writes: port B first, then port A so that A wins on a shared address
    always_ff @(posedge clk) begin
        if (b_we) words[b_addr] <= b_wdata;
        if (a_we) words[a_addr] <= a_wdata;
    end

    // Reads: capture the pre-write word, hold it until the next read
    always_ff @(posedge clk) begin
        if (a_re) a_rdata <= words[a_addr];
        if (b_re) b_rdata <= words[b_addr];
    end

endmodule

// File: rtl/mbx_flag_ctrl.sv
// Module: ready-flag register, write guard for the data window, collision
// detection and flag read-back capture for both ports.
// Assumes: port A is the producer and wins every simultaneous flag write;
// only bit 0 of a flag write is kept.
module mbx_flag_ctrl #(
    parameter int AW         = 10,
    parameter int FLAG_ADDR  = 1023,
    parameter int DATA_BASE  = 1016,
    parameter int DATA_WORDS = 4,
    localparam int AW1       = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          a_en,
    input  logic          a_we,
    input  logic [AW-1:0] a_addr,
    input  logic          a_bit0,
    input  logic          b_en,
    input  logic          b_we,
    input  logic [AW-1:0] b_addr,
    input  logic          b_bit0,
    output logic          flag_q,
    output logic          flag_rise,
    output logic          a_mem_we,
    output logic          a_mem_re,
    output logic          b_mem_we,
    output logic          b_mem_re,
    output logic          a_rsel_flag,
    output logic          a_rflag,
    output logic          b_rsel_flag,
    output logic          b_rflag,
    output logic          collide
);

    localparam logic [AW-1:0] FLAG_A = AW'(FLAG_ADDR);
    localparam logic [AW:0]   WIN_LO = AW1'(DATA_BASE);
    localparam logic [AW:0]   WIN_HI = AW1'(DATA_BASE + DATA_WORDS);

    logic a_hit_flag, b_hit_flag;
    logic a_flag_wr, b_flag_wr;
    logic a_in_win;
    logic flag_nxt;

    // Decode: which accesses target the flag word or the data window
    always_comb begin
        a_hit_flag = (a_addr == FLAG_A);
        b_hit_flag = (b_addr == FLAG_A);
        a_flag_wr  = a_en && a_we && a_hit_flag;
        b_flag_wr  = b_en && b_we && b_hit_flag;
        a_in_win   = ({1'b0, a_addr} >= WIN_LO) && ({1'b0, a_addr} < WIN_HI);
    end

    // Next flag: producer write first, then consumer write, else hold
    always_comb begin
        if (a_flag_wr)      flag_nxt = a_bit0;
        else if (b_flag_wr) flag_nxt = b_bit0;
        else                flag_nxt = flag_q;
        flag_rise = flag_nxt && !flag_q;
    end

    // Store enables: flag word never reaches the array; full window guarded
    always_comb begin
        a_mem_we = a_en && a_we && !a_hit_flag && !(flag_q && a_in_win);
        b_mem_we = b_en && b_we && !b_hit_flag;
        a_mem_re = a_en && !a_we && !a_hit_flag;
        b_mem_re = b_en && !b_we && !b_hit_flag;
    end

    // Flag register and collision report
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q  <= 1'b0;
            collide <= 1'b0;
        end else begin
            flag_q  <= flag_nxt;
            collide <= a_flag_wr && b_flag_wr;
        end
    end

    // Flag read-back capture per port, held until that port reads again
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_rsel_flag <= 1'b0;
            a_rflag     <= 1'b0;
            b_rsel_flag <= 1'b0;
            b_rflag     <= 1'b0;
        end else begin
            if (a_en && !a_we) begin
                a_rsel_flag <= a_hit_flag;
                a_rflag     <= flag_q;
            end
            if (b_en && !b_we) begin
                b_rsel_flag <= b_hit_flag;
                b_rflag     <= flag_q;
            end
        end
    end

endmodule

// File: rtl/mbx_notify.sv
// Module: consumer notify line, either the flag level or an edge pulse.
// Assumes: flag_rise is high in the cycle before flag_q turns 1.
module mbx_notify
    import mbx_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  notify_form_e form,
    input  logic         flag_q,
    input  logic         flag_rise,
    output logic         notify
);

    logic pulse_q;

    // Pulse register aligned with the flag update
    always_ff @(posedge clk) begin
        if (!rst_n) pulse_q <= 1'b0;
        else        pulse_q <= flag_rise;
    end

    // Output select by configured form
    always_comb begin
        notify = (form == NOTIFY_PULSE) ? pulse_q : flag_q;
    end

endmodule

// File: rtl/mbx_mailbox.sv
// Module: top of the two-port mailbox. Port A is the producer, port B the
// consumer. Combines the word store, flag control and notify line.
// Assumes: both ports are synchronous to clk; reset is synchronous, active low.
module mbx_mailbox
    import mbx_pkg::*;
#(
    parameter int DW         = MBX_DATA_W,
    parameter int DEPTH      = MBX_DEPTH,
    parameter int FLAG_ADDR  = DEPTH - 1,
    parameter int DATA_WORDS = 4,
    parameter int DATA_BASE  = DEPTH - 8,
    localparam int AW        = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_irq_mode,
    input  logic          a_en,
    input  logic          a_we,
    input  logic [AW-1:0] a_addr,
    input  logic [DW-1:0] a_wdata,
    output logic [DW-1:0] a_rdata,
    input  logic          b_en,
    input  logic          b_we,
    input  logic [AW-1:0] b_addr,
    input  logic [DW-1:0] b_wdata,
    output logic [DW-1:0] b_rdata,
    output logic          notify,
    output logic          collide
);

    logic          flag_q, flag_rise;
    logic          a_mem_we, a_mem_re, b_mem_we, b_mem_re;
    logic          a_rsel_flag, a_rflag, b_rsel_flag, b_rflag;
    logic [DW-1:0] a_mem_rdata, b_mem_rdata;
    notify_form_e  form;

    mbx_flag_ctrl #(
        .AW(AW), .FLAG_ADDR(FLAG_ADDR),
        .DATA_BASE(DATA_BASE), .DATA_WORDS(DATA_WORDS)
    ) i_flag (
        .clk(clk), .rst_n(rst_n),
        .a_en(a_en), .a_we(a_we), .a_addr(a_addr), .a_bit0(a_wdata[0]),
        .b_en(b_en), .b_we(b_we), .b_addr(b_addr), .b_bit0(b_wdata[0]),
        .flag_q(flag_q), .flag_rise(flag_rise),
        .a_mem_we(a_mem_we), .a_mem_re(a_mem_re),
        .b_mem_we(b_mem_we), .b_mem_re(b_mem_re),
        .a_rsel_flag(a_rsel_flag), .a_rflag(a_rflag),
        .b_rsel_flag(b_rsel_flag), .b_rflag(b_rflag),
        .collide(collide)
    );

    mbx_store #(.DW(DW), .DEPTH(DEPTH)) i_store (
        .clk(clk),
        .a_we(a_mem_we), .a_re(a_mem_re), .a_addr(a_addr),
        .a_wdata(a_wdata), .a_rdata(a_mem_rdata),
        .b_we(b_mem_we), .b_re(b_mem_re), .b_addr(b_addr),
        .b_wdata(b_wdata), .b_rdata(b_mem_rdata)
    );

    // Map the configuration bit onto the notify form
    always_comb form = cfg_irq_mode ? NOTIFY_PULSE : NOTIFY_LEVEL;

    mbx_notify i_notify (
        .clk(clk), .rst_n(rst_n), .form(form),
        .flag_q(flag_q), .flag_rise(flag_rise), .notify(notify)
    );

    // Read data: flag word as a zero-extended bit, else the stored word
    always_comb begin
        a_rdata = a_rsel_flag ? {{(DW-1){1'b0}}, a_rflag} : a_mem_rdata;
        b_rdata = b_rsel_flag ? {{(DW-1){1'b0}}, b_rflag} : b_mem_rdata;
    end

endmodule

// File: rtl/mbx_mailbox_chk.sv
// Module: property checker for the mailbox, bound into mbx_mailbox.
// Assumes: sees the top ports plus the flag register and the guarded
// port A store enable.
module mbx_mailbox_chk #(
    parameter int AW         = 10,
    parameter int FLAG_ADDR  = 1023,
    parameter int DATA_BASE  = 1016,
    parameter int DATA_WORDS = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cfg_irq_mode,
    input logic          a_en,
    input logic          a_we,
    input logic [AW-1:0] a_addr,
    input logic          a_bit0,
    input logic          b_en,
    input logic          b_we,
    input logic [AW-1:0] b_addr,
    input logic          flag_q,
    input logic          a_mem_we,
    input logic          notify,
    input logic          collide
);

    logic a_fw, b_fw, a_win;

    // Independent decode of flag writes and window hits
    always_comb begin
        a_fw  = a_en && a_we && (int'(a_addr) == FLAG_ADDR);
        b_fw  = b_en && b_we && (int'(b_addr) == FLAG_ADDR);
        a_win = (int'(a_addr) >= DATA_BASE) && (int'(a_addr) < DATA_BASE + DATA_WORDS);
    end

    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (!flag_q && !notify && !collide));

    a_r4_window_guard: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && a_en && a_we && a_win) |-> !a_mem_we);

    a_r6_collide_a_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (a_fw && b_fw) |=> (collide && (flag_q == $past(a_bit0))));

    a_r6_collide_only_then: assert property (@(posedge clk) disable iff (!rst_n)
        collide |-> $past(a_fw && b_fw));

    a_r7_poll_level: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_irq_mode |-> (notify == flag_q));

    a_r8_pulse_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_irq_mode && notify) |-> $rose(flag_q));

    a_r8_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_irq_mode && notify) |=> (!notify || !cfg_irq_mode));

endmodule

bind mbx_mailbox mbx_mailbox_chk #(
    .AW(AW), .FLAG_ADDR(FLAG_ADDR),
    .DATA_BASE(DATA_BASE), .DATA_WORDS(DATA_WORDS)
) i_chk (
    .clk(clk), .rst_n(rst_n), .cfg_irq_mode(cfg_irq_mode),
    .a_en(a_en), .a_we(a_we), .a_addr(a_addr), .a_bit0(a_wdata[0]),
    .b_en(b_en), .b_we(b_we), .b_addr(b_addr),
    .flag_q(flag_q), .a_mem_we(a_mem_we),
    .notify(notify), .collide(collide)
);

// File: tb/test_mbx_mailbox.sv
// Directed bench for mbx_mailbox: one task per scenario, each self-checking.
module test_mbx_mailbox;

    localparam int DW   = 16;
    localparam int AW   = 10;
    localparam int FLAG = 1023;
    localparam int WIN  = 1016;
    localparam int NSTREAM = 40;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_irq_mode = 1'b0;
    logic          a_en = 1'b0, a_we = 1'b0;
    logic [AW-1:0] a_addr = '0;
    logic [DW-1:0] a_wdata = '0;
    logic [DW-1:0] a_rdata;
    logic          b_en = 1'b0, b_we = 1'b0;
    logic [AW-1:0] b_addr = '0;
    logic [DW-1:0] b_wdata = '0;
    logic [DW-1:0] b_rdata;
    logic          notify, collide;

    int total = 0;
    int bad   = 0;
    int cycles = 0;
    bit ended = 0;

    mbx_mailbox i_mbx_mailbox (
        .clk(clk), .rst_n(rst_n), .cfg_irq_mode(cfg_irq_mode),
        .a_en(a_en), .a_we(a_we), .a_addr(a_addr), .a_wdata(a_wdata), .a_rdata(a_rdata),
        .b_en(b_en), .b_we(b_we), .b_addr(b_addr), .b_wdata(b_wdata), .b_rdata(b_rdata),
        .notify(notify), .collide(collide)
    );

    always #10 clk = ~clk;

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as a failed check
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            total++; bad++;
            $display("FAIL watchdog: actual=%0d cycles expected<=100000", cycles);
            finish_run();
        end
    end

    task automatic check(string req, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic a_wr(int addr, int data);
        @(negedge clk);
        a_en = 1; a_we = 1; a_addr = AW'(addr); a_wdata = DW'(data);
        @(negedge clk);
        a_en = 0; a_we = 0;
    endtask

    task automatic a_rd(int addr, output int data);
        @(negedge clk);
        a_en = 1; a_we = 0; a_addr = AW'(addr);
        @(negedge clk);
        a_en = 0;
        data = int'(a_rdata);
    endtask

    task automatic b_wr(int addr, int data);
        @(negedge clk);
        b_en = 1; b_we = 1; b_addr = AW'(addr); b_wdata = DW'(data);
        @(negedge clk);
        b_en = 0; b_we = 0;
    endtask

    task automatic b_rd(int addr, output int data);
        @(negedge clk);
        b_en = 1; b_we = 0; b_addr = AW'(addr);
        @(negedge clk);
        b_en = 0;
        data = int'(b_rdata);
    endtask

    task automatic t_reset();
        int v;
        check("R1 notify after reset", int'(notify), 0);
        check("R1 collide after reset", int'(collide), 0);
        b_rd(FLAG, v);
        check("R1 flag empty after reset", v, 0);
    endtask

    task automatic t_cross_port();
        int v;
        a_wr(100, 16'h1234);
        b_rd(100, v);
        check("R2 A write seen by B", v, 16'h1234);
        b_wr(200, 16'hBEEF);
        a_rd(200, v);
        check("R2 B write seen by A", v, 16'hBEEF);
        a_wr(100, 16'h5555);
        check("R2 B rdata held until next read", int'(b_rdata), 16'h1234);
    endtask

    task automatic t_flag_word();
        int v;
        a_wr(FLAG, 16'hFFFE);
        b_rd(FLAG, v);
        check("R3 upper bits ignored, bit0=0", v, 0);
        a_wr(FLAG, 16'h0003);
        b_rd(FLAG, v);
        check("R3 flag reads as 0x0001", v, 1);
        b_wr(FLAG, 0);
        a_rd(FLAG, v);
        check("R3 consumer clear", v, 0);
    endtask

    task automatic t_poll_mode();
        cfg_irq_mode = 0;
        a_wr(FLAG, 1);
        check("R7 poll notify follows set", int'(notify), 1);
        @(negedge clk);
        check("R7 poll notify stays high", int'(notify), 1);
        b_wr(FLAG, 0);
        check("R7 poll notify follows clear", int'(notify), 0);
    endtask

    task automatic t_irq_mode();
        cfg_irq_mode = 1;
        a_wr(FLAG, 1);
        check("R8 pulse on rise", int'(notify), 1);
        @(negedge clk);
        check("R8 pulse lasts one cycle", int'(notify), 0);
        a_wr(FLAG, 1);
        check("R8 no pulse when already full", int'(notify), 0);
        b_wr(FLAG, 0);
        a_wr(FLAG, 1);
        check("R8 pulse on second rise", int'(notify), 1);
        b_wr(FLAG, 0);
        cfg_irq_mode = 0;
    endtask

    task automatic t_guard();
        int v;
        a_wr(WIN + 1, 16'hAAAA);
        a_wr(FLAG, 1);
        a_wr(WIN + 1, 16'h7777);
        b_rd(WIN + 1, v);
        check("R4 window write while full ignored", v, 16'hAAAA);
        a_wr(300, 16'h3C3C);
        b_rd(300, v);
        check("R5 outside-window write while full", v, 16'h3C3C);
        b_wr(FLAG, 0);
        a_wr(WIN + 1, 16'h7777);
        b_rd(WIN + 1, v);
        check("R4 window write after clear", v, 16'h7777);
    endtask

    task automatic both_wr(int addr, int da, int db);
        @(negedge clk);
        a_en = 1; a_we = 1; a_addr = AW'(addr); a_wdata = DW'(da);
        b_en = 1; b_we = 1; b_addr = AW'(addr); b_wdata = DW'(db);
        @(negedge clk);
        a_en = 0; a_we = 0; b_en = 0; b_we = 0;
    endtask

    task automatic t_collision();
        int v;
        both_wr(FLAG, 1, 0);
        check("R6 collide reported", int'(collide), 1);
        @(negedge clk);
        check("R6 collide one cycle", int'(collide), 0);
        b_rd(FLAG, v);
        check("R6 A set wins", v, 1);
        both_wr(FLAG, 0, 1);
        check("R6 collide on second clash", int'(collide), 1);
        a_rd(FLAG, v);
        check("R6 A clear wins", v, 0);
        both_wr(50, 16'h0A0A, 16'h0B0B);
        check("R6 no collide on data address", int'(collide), 0);
        b_rd(50, v);
        check("R9 A wins on shared data address", v, 16'h0A0A);
    endtask

    task automatic t_read_old();
        a_wr(60, 16'h1111);
        @(negedge clk);
        a_en = 1; a_we = 1; a_addr = AW'(60); a_wdata = 16'h2222;
        b_en = 1; b_we = 0; b_addr = AW'(60);
        @(negedge clk);
        a_en = 0; a_we = 0; b_en = 0;
        check("R10 same-cycle read returns old word", int'(b_rdata), 16'h1111);
    endtask

    task automatic t_stream();
        int got = 0;
        int errs = 0;
        fork
            begin : producer
                for (int i = 0; i < NSTREAM; i++) begin
                    int f;
                    do begin
                        repeat ($urandom_range(0, 3)) @(negedge clk);
                        a_rd(FLAG, f);
                    end while (f != 0);
                    a_wr(WIN, 16'h4000 + i);
                    a_wr(FLAG, 1);
                end
            end
            begin : consumer
                for (int k = 0; k < NSTREAM; k++) begin
                    int f, d;
                    do begin
                        repeat ($urandom_range(0, 4)) @(negedge clk);
                        b_rd(FLAG, f);
                    end while (f != 1);
                    b_rd(WIN, d);
                    b_wr(FLAG, 0);
                    if (d != 16'h4000 + k) begin
                        errs++;
                        check("R11 stream word in order", d, 16'h4000 + k);
                    end
                    got++;
                end
            end
        join
        check("R11 stream words received", got, NSTREAM);
        check("R11 stream without loss or duplicate", errs, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 notify during reset", int'(notify), 0);
        rst_n = 1;
        t_reset();
        t_cross_port();
        t_flag_word();
        t_poll_mode();
        t_irq_mode();
        t_guard();
        t_collision();
        t_read_old();
        t_stream();
        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule